// File: doc/BRIEF.md
# Capture Timebase Counter with Trigger, Sync and Cascade Options

This block is the free-standing time reference that a capture channel samples when an input event occurs. It is a synchronous up-counter (16 bits by default) that advances only on cycles where a timer-clock enable is high. Choosing and dividing that clock happens outside the block. The count output serves directly as the timestamp. While the counter is held at zero, the timestamp therefore reads zero.

Four ways of running are available. In the free option the counter steps on every enabled tick and wraps to zero after all ones. In the synchronised option a level on the sync input clears the counter, which stays at zero until the level drops. In the triggered option the counter waits at zero until an armed status bit is set. A rising edge of the sync/trigger input sets that bit, and so does a software strobe. A software clear strobe drops the bit, zeroes the counter and re-arms it. In the chained option two instances form one wide counter. The lower instance runs on every tick. The upper instance has its chain input tied to the lower instance's all-ones output, so it steps only on ticks where the lower half wraps.

Top module: `ctb_timebase`

## Requirements
- R1: While `enable` is 0 (and during reset), the count is 0, `trig_status` is 0 and `cascade_out` is 0. The cycle after `enable` falls, the count reads 0.
- R2: With `enable`=1, `trig_mode`=0, `sync_sel`=0 and `cascade_en`=0, each cycle with `tick`=1 raises the count by one from one clock to the next, and the count wraps from all ones to 0. A cycle with `tick`=0 leaves the count unchanged.
- R3: With `trig_mode`=0 and `sync_sel`=1, a tick while `sync_in`=1 sets the count to 0. The count stays 0 on further ticks while `sync_in` remains 1, and it reads 1 after the first tick with `sync_in`=0.
- R4: With `trig_mode`=1, the count is 0 in the cycle after any cycle in which `trig_status` is 0, whatever `tick` does. The timestamp taken during that hold is therefore 0.
- R5: With `trig_mode`=1, a tick where `sync_in` is 1 and was 0 at the previous tick sets `trig_status` at that edge. The count stays 0 on that tick and reads 1 after the next tick.
- R6: With `trig_mode`=1, `sw_trig_set` sets `trig_status` on the next clock. `sw_trig_clr` clears `trig_status` and sets the count to 0 on the next clock, and it wins when both strobes are high together.
- R7: Arming follows the edge, not the level: after a software clear with `sync_in` held at 1, further ticks leave `trig_status` at 0 until `sync_in` has been sampled at 0 on a tick and then at 1 on a later tick.
- R8: With `trig_mode`=0, `trig_status` reads 0 the cycle after, and the software strobes do not change the count.
- R9: `cascade_out` is 1 exactly when `enable` is 1 and the count is all ones.
- R10: With `cascade_en`=1, a tick changes the count only while `cascade_in` is 1. Without a tick, or with `cascade_in`=0, the count holds.
- R11: Two instances chained (upper `cascade_in` fed by lower `cascade_out`, only the upper with `cascade_en`=1) form one counter of twice the width, with the lower instance as the low half. The combined value goes from 0000FFFFh to 00010000h on a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block on; when 0, the counter and the status are forced to 0 |
| tick | input | 1 | Timer-clock enable; the counter may advance only on these cycles |
| trig_mode | input | 1 | 1 selects triggered operation |
| sync_sel | input | 1 | 1 selects synchronised operation (when `trig_mode`=0) |
| sync_in | input | 1 | Sync level / trigger edge source, synchronous to `clk` |
| sw_trig_set | input | 1 | Software strobe that sets the trigger status |
| sw_trig_clr | input | 1 | Software strobe that clears the trigger status and zeroes the counter |
| cascade_en | input | 1 | 1 gates ticks by `cascade_in` (upper half of a pair) |
| cascade_in | input | 1 | Chain input from the lower half's `cascade_out` |
| cascade_out | output | 1 | High while the block is enabled and the count is all ones |
| count | output | WIDTH | Current counter value, used as the capture timestamp |
| trig_status | output | 1 | Trigger status; 1 means released and running |

## Verification
The assertions assume that `sync_in`, `tick` and the software strobes are synchronous to `clk`. They also assume that a trigger pulse is seen on at least one tick, because the edge detector samples only on ticks. The stimulus drives every input away from the active edge and holds it for a whole clock. The random phase makes the software clear strobe rare and keeps `enable` high most of the time, so that long triggered runs occur. The directed pair run holds `tick` high for one full lower-half period, so the chained wrap is reached without forcing any state.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

   typedef enum logic [1:0] {
      CTB_OFF  = 2'd0,
      CTB_FREE = 2'd1,
      CTB_SYNC = 2'd2,
      CTB_TRIG = 2'd3
   } ctb_mode_e;

   typedef struct packed {
      logic clear;
      logic step;
   } ctb_cmd_t;

endpackage

// File: rtl/ctb_mode_decode.sv
module ctb_mode_decode
   import ctb_pkg::*;
(
   input  logic      enable,
   input  logic      trig_mode,
   input  logic      sync_sel,
   output ctb_mode_e mode
);
   always_comb begin
      if (!enable)        mode = CTB_OFF;
      else if (trig_mode) mode = CTB_TRIG;
      else if (sync_sel)  mode = CTB_SYNC;
      else                mode = CTB_FREE;
   end
endmodule

// File: rtl/ctb_trig_arm.sv
module ctb_trig_arm
   import ctb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctb_mode_e mode,
   input  logic      sample_en,
   input  logic      sync_in,
   input  logic      sw_set,
   input  logic      sw_clr,
   output logic      status
);
   logic prev_q;
   logic rise;

   assign rise = sample_en && sync_in && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else if (sample_en) begin
         prev_q <= sync_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (mode != CTB_TRIG) begin
         status <= 1'b0;
      end else if (sw_clr) begin
         status <= 1'b0;
      end else if (sw_set || rise) begin
         status <= 1'b1;
      end
   end
endmodule

// File: rtl/ctb_step_ctl.sv
module ctb_step_ctl
   import ctb_pkg::*;
(
   input  ctb_mode_e mode,
   input  logic      tick,
   input  logic      sync_in,
   input  logic      status,
   input  logic      sw_clr,
   input  logic      cascade_en,
   input  logic      cascade_in,
   output ctb_cmd_t  cmd
);
   logic advance;

   assign advance = tick && (!cascade_en || cascade_in);

   always_comb begin
      cmd = '0;
      unique case (mode)
         CTB_OFF: begin
            cmd.clear = 1'b1;
         end
         CTB_FREE: begin
            cmd.step = advance;
         end
         CTB_SYNC: begin
            if (tick && sync_in) cmd.clear = 1'b1;
            else                 cmd.step  = advance;
         end
         CTB_TRIG: begin
            if (sw_clr || !status) cmd.clear = 1'b1;
            else                   cmd.step  = advance;
         end
         default: cmd.clear = 1'b1;
      endcase
   end
endmodule

// File: rtl/ctb_count_core.sv
module ctb_count_core
   import ctb_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctb_cmd_t         cmd,
   output logic [WIDTH-1:0] count,
   output logic             at_max
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cmd.clear) begin
         count <= '0;
      end else if (cmd.step) begin
         count <= count + ONE;
      end
   end

   assign at_max = &count;
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
   import ctb_pkg::*;
#(
   parameter int WIDTH          = 16,
   parameter bit SAMPLE_ON_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             trig_mode,
   input  logic             sync_sel,
   input  logic             sync_in,
   input  logic             sw_trig_set,
   input  logic             sw_trig_clr,
   input  logic             cascade_en,
   input  logic             cascade_in,
   output logic             cascade_out,
   output logic [WIDTH-1:0] count,
   output logic             trig_status
);
   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("ctb_timebase: WIDTH must lie in 2..64");
   end

   ctb_mode_e mode;
   ctb_cmd_t  cmd;
   logic      sample_en;
   logic      at_max;

   if (SAMPLE_ON_TICK) begin : g_edge_tick
      assign sample_en = tick;
   end else begin : g_edge_clk
      assign sample_en = 1'b1;
   end

   ctb_mode_decode u_dec (
      .enable    (enable),
      .trig_mode (trig_mode),
      .sync_sel  (sync_sel),
      .mode      (mode)
   );

   ctb_trig_arm u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .sample_en (sample_en),
      .sync_in   (sync_in),
      .sw_set    (sw_trig_set),
      .sw_clr    (sw_trig_clr),
      .status    (trig_status)
   );

   ctb_step_ctl u_step (
      .mode       (mode),
      .tick       (tick),
      .sync_in    (sync_in),
      .status     (trig_status),
      .sw_clr     (sw_trig_clr),
      .cascade_en (cascade_en),
      .cascade_in (cascade_in),
      .cmd        (cmd)
   );

   ctb_count_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .count  (count),
      .at_max (at_max)
   );

   assign cascade_out = at_max && (mode != CTB_OFF);
endmodule

// File: rtl/ctb_timebase_chk.sv
module ctb_timebase_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             tick,
   input logic             trig_mode,
   input logic             sync_sel,
   input logic             sync_in,
   input logic             sw_trig_clr,
   input logic             cascade_en,
   input logic             cascade_in,
   input logic             cascade_out,
   input logic [WIDTH-1:0] count,
   input logic             trig_status
);
   localparam logic [WIDTH-1:0] ALL1 = '1;

   a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (count == '0));

   a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !trig_mode && !sync_sel && !cascade_en && tick)
      |=> (count == WIDTH'($past(count) + 1'b1)));

   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !trig_mode && !tick) |=> $stable(count));

   a_r3_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !trig_mode && sync_sel && tick && sync_in) |=> (count == '0));

   a_r4_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && trig_mode && !trig_status) |=> (count == '0));

   a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && trig_mode && sw_trig_clr) |=> (count == '0 && !trig_status));

   a_r8_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_mode |=> !trig_status);

   a_r9_chain_out: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_out |-> (enable && count == ALL1));

   a_r10_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cascade_en && !cascade_in && !trig_mode && !sync_sel)
      |=> $stable(count));
endmodule

bind ctb_timebase ctb_timebase_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .tick        (tick),
   .trig_mode   (trig_mode),
   .sync_sel    (sync_sel),
   .sync_in     (sync_in),
   .sw_trig_clr (sw_trig_clr),
   .cascade_en  (cascade_en),
   .cascade_in  (cascade_in),
   .cascade_out (cascade_out),
   .count       (count),
   .trig_status (trig_status)
);

// File: tb/ctb_timebase_test.sv
module ctb_timebase_test;
   localparam int TCLK = 10;

   typedef struct packed {
      logic [15:0] c;
      logic        s;
      logic        p;
   } st_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 0, tick = 0, trig_mode = 0, sync_sel = 0, sync_in = 0;
   logic sw_set = 0, sw_clr = 0, lo_cen = 0, lo_cin = 0, hi_cen = 1;
   logic lo_cout, hi_cout, lo_stat, hi_stat;
   logic [15:0] lo_cnt, hi_cnt;
   int n_chk = 0, n_bad = 0;
   bit done = 0;
   st_t lo_q = '0, hi_q = '0;

   always #(TCLK/2) clk = ~clk;

   ctb_timebase uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
      .trig_mode(trig_mode), .sync_sel(sync_sel), .sync_in(sync_in),
      .sw_trig_set(sw_set), .sw_trig_clr(sw_clr),
      .cascade_en(lo_cen), .cascade_in(lo_cin), .cascade_out(lo_cout),
      .count(lo_cnt), .trig_status(lo_stat)
   );

   ctb_timebase uut_hi (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
      .trig_mode(trig_mode), .sync_sel(sync_sel), .sync_in(sync_in),
      .sw_trig_set(sw_set), .sw_trig_clr(sw_clr),
      .cascade_en(hi_cen), .cascade_in(lo_cout), .cascade_out(hi_cout),
      .count(hi_cnt), .trig_status(hi_stat)
   );

   function automatic st_t nxt(st_t q, logic en, logic tk, logic trg, logic ssel,
                               logic sin, logic sset, logic sclr, logic cen, logic cin);
      st_t n = q;
      logic rise = tk && sin && !q.p;
      logic adv  = tk && (!cen || cin);
      if (tk) n.p = sin;
      if (!en) begin
         n.c = '0; n.s = 1'b0;
      end else if (trg) begin
         if (sclr) begin
            n.c = '0; n.s = 1'b0;
         end else begin
            if (!q.s)     n.c = '0;
            else if (adv) n.c = q.c + 16'd1;
            if (sset || rise) n.s = 1'b1;
         end
      end else begin
         n.s = 1'b0;
         if (ssel && tk && sin) n.c = '0;
         else if (adv)          n.c = q.c + 16'd1;
      end
      return n;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_cmp(string req);
      chk(req, "lo count",  32'(lo_cnt),  32'(lo_q.c));
      chk(req, "lo status", 32'(lo_stat), 32'(lo_q.s));
      chk(req, "lo chain",  32'(lo_cout), 32'(enable && lo_q.c == 16'hFFFF));
      chk(req, "hi count",  32'(hi_cnt),  32'(hi_q.c));
   endtask

   task automatic cyc(bit cmp = 1);
      logic hcin;
      @(posedge clk);
      hcin = enable && lo_q.c == 16'hFFFF;
      lo_q = nxt(lo_q, enable, tick, trig_mode, sync_sel, sync_in, sw_set, sw_clr, lo_cen, lo_cin);
      hi_q = nxt(hi_q, enable, tick, trig_mode, sync_sel, sync_in, sw_set, sw_clr, hi_cen, hcin);
      @(negedge clk);
      if (cmp) model_cmp("model");
   endtask

   initial begin
      #(TCLK * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h1C5A7);
      repeat (3) @(negedge clk);
      chk("R1", "reset count",  32'(lo_cnt),  0);
      chk("R1", "reset status", 32'(lo_stat), 0);
      chk("R1", "reset chain",  32'(lo_cout), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 free running, hold without tick
      enable = 1; tick = 1;
      repeat (3) cyc();
      chk("R2", "three ticks", 32'(lo_cnt), 3);
      tick = 0;
      repeat (2) cyc();
      chk("R2", "no tick hold", 32'(lo_cnt), 3);

      // R3 sync level hold
      sync_sel = 1; sync_in = 1; tick = 1;
      cyc();
      chk("R3", "sync clears", 32'(lo_cnt), 0);
      repeat (2) cyc();
      chk("R3", "sync holds", 32'(lo_cnt), 0);
      sync_in = 0;
      cyc();
      chk("R3", "resume", 32'(lo_cnt), 1);

      // R4 / R5 triggered operation
      trig_mode = 1; sync_sel = 0;
      repeat (3) cyc();
      chk("R4", "held zero timestamp", 32'(lo_cnt), 0);
      chk("R4", "status idle", 32'(lo_stat), 0);
      sync_in = 1;
      cyc();
      chk("R5", "edge arms", 32'(lo_stat), 1);
      chk("R5", "still zero", 32'(lo_cnt), 0);
      cyc();
      chk("R5", "first count", 32'(lo_cnt), 1);
      cyc();
      chk("R5", "second count", 32'(lo_cnt), 2);

      // R6 software clear, R7 level does not re-arm
      tick = 0; sw_clr = 1;
      cyc();
      sw_clr = 0;
      chk("R6", "clr count", 32'(lo_cnt), 0);
      chk("R6", "clr status", 32'(lo_stat), 0);
      tick = 1;
      repeat (3) cyc();
      chk("R7", "level no rearm", 32'(lo_stat), 0);
      chk("R7", "level count", 32'(lo_cnt), 0);
      sync_in = 0; cyc();
      sync_in = 1; cyc();
      chk("R7", "new edge arms", 32'(lo_stat), 1);
      sync_in = 0;
      sw_set = 1; sw_clr = 1; tick = 0;
      cyc();
      chk("R6", "clear wins", 32'(lo_stat), 0);
      sw_clr = 0;
      cyc();
      sw_set = 0;
      chk("R6", "sw set", 32'(lo_stat), 1);
      tick = 1;
      cyc();
      chk("R6", "runs after set", 32'(lo_cnt), 1);

      // R8 status ignored outside triggered mode
      trig_mode = 0;
      cyc();
      chk("R8", "status drops", 32'(lo_stat), 0);
      chk("R8", "counts on", 32'(lo_cnt), 2);
      sw_clr = 1; sw_set = 1;
      cyc();
      sw_clr = 0; sw_set = 0;
      chk("R8", "strobes ignored", 32'(lo_cnt), 3);
      chk("R8", "status stays 0", 32'(lo_stat), 0);

      // R10 chain gating on the lower instance
      lo_cen = 1; lo_cin = 0;
      repeat (2) cyc();
      chk("R10", "gated hold", 32'(lo_cnt), 3);
      lo_cin = 1;
      cyc();
      chk("R10", "gated step", 32'(lo_cnt), 4);
      lo_cen = 0; lo_cin = 0;

      // R1 off forces zero
      enable = 0;
      cyc();
      chk("R1", "off count", 32'(lo_cnt), 0);
      chk("R1", "off hi", 32'(hi_cnt), 0);
      chk("R1", "off chain", 32'(lo_cout), 0);

      // R11 chained pair across the low-half wrap
      enable = 1; tick = 1;
      repeat (65535) cyc(0);
      model_cmp("R11");
      chk("R9", "chain at all ones", 32'(lo_cout), 1);
      chk("R11", "pair 0000FFFF", {hi_cnt, lo_cnt}, 32'h0000FFFF);
      cyc();
      chk("R11", "pair 00010000", {hi_cnt, lo_cnt}, 32'h00010000);
      chk("R2", "wrap to zero", 32'(lo_cnt), 0);
      chk("R9", "chain drops", 32'(lo_cout), 0);

      // random phase against the model
      for (int i = 0; i < 3000; i++) begin
         enable    = ($urandom_range(0, 19) != 0);
         tick      = ($urandom_range(0, 3) != 0);
         trig_mode = ($urandom_range(0, 2) == 0);
         sync_sel  = $urandom_range(0, 1);
         sync_in   = ($urandom_range(0, 3) == 0);
         sw_set    = ($urandom_range(0, 29) == 0);
         sw_clr    = ($urandom_range(0, 49) == 0);
         lo_cen    = ($urandom_range(0, 4) == 0);
         lo_cin    = $urandom_range(0, 1);
         cyc(0);
         model_cmp("R2,R3,R4,R5,R6,R8,R10");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule